// File: doc/BRIEF.md
# Bit Test, Modify and Scan Unit

This unit performs single-bit operations on an operand and leading-one searches over it. For a bit operation it picks one bit of the operand by a bit number, reports whether that bit was zero before any change, and returns the operand with that bit left alone, forced low, forced high or inverted. For a scan it searches the operand either upward from bit 0 or downward from the top of the chosen width, returns the position of the first one it meets, and raises an empty flag when no bit is set.

A width select chooses between a narrow and a full view of the operand. For bit operations, narrow is the 8-bit view used for memory bytes and full is the 32-bit view used for registers. For scans, narrow is a 16-bit view and full is the 32-bit view. One request may be presented each cycle. Its result appears on registered outputs one clock later, qualified by a valid strobe, and stays there until the next request. Opcode decoding and operand fetch belong to the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: With `in_op` = 0 (test), `out_result` equals the operand unchanged, and `out_zero` is 1 exactly when the selected bit of the operand is 0.
- R2: With `in_wide` = 1, `in_op` = 1, 2 and 3 write the selected bit to 0, write it to 1, or invert it. All other bits are unchanged. `out_zero` reflects the bit's value before the write. The selected position is the bit number modulo 32.
- R3: With `in_wide` = 0, bit operations use the bit number modulo 8. `out_result[31:8]` always equals `in_operand[31:8]`.
- R4: With `in_op` = 4 (upward scan), `out_index` is the lowest set bit position within bits 15:0 (`in_wide` = 0) or 31:0 (`in_wide` = 1). Bits above the width are ignored.
- R5: With `in_op` = 5 (downward scan), `out_index` is the highest set bit position within the selected width, searching from bit 15 or bit 31.
- R6: For a scan, `out_result` equals the operand. If no bit in the width is set, `out_empty` = 1, `out_zero` = 1 and `out_index` = 0. Otherwise `out_empty` = 0 and `out_zero` = 0.
- R7: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1. While `in_valid` is 0, `out_result`, `out_zero`, `out_index` and `out_empty` keep their values.
- R8: A synchronous active-low reset clears all outputs to 0.
- R9: Opcodes 6 and 7 behave as test (R1). For every non-scan opcode, `out_empty` = 0 and `out_index` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 test, 1 clear, 2 set, 3 invert, 4 upward scan, 5 downward scan) |
| in_wide | input | 1 | 1 selects the 32-bit view; 0 selects 8-bit (bit ops) or 16-bit (scans) |
| in_operand | input | 32 | Operand |
| in_bitnum | input | 8 | Bit number, reduced modulo the width |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Operand after modification |
| out_zero | output | 1 | Tested bit was 0, or scan found nothing |
| out_index | output | 5 | Scan position of the first set bit |
| out_empty | output | 1 | Scan found no set bit |

## Verification
The hardest cases to reach are a scan whose set bits all lie above bit 15 while the 16-bit view is selected, and a bit number of 32 or more that must wrap. Purely random operands almost never produce either case. The stimulus therefore sends directed requests with only the upper half populated, single-bit and all-ones operands at both ends of each width, and bit numbers near 8, 32 and 255. It then follows with random requests whose operands are sometimes masked down to a single bit or a single half. Idle gaps between requests exercise the hold behaviour.

// File: rtl/bitop_pkg.sv
// Shared definitions for the bit test/modify/scan unit.
// Assumes the opcode field is three bits wide; codes 6 and 7 are reserved.
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_TEST    = 3'd0,
        OP_CLEAR   = 3'd1,
        OP_SET     = 3'd2,
        OP_INVERT  = 3'd3,
        OP_SCAN_UP = 3'd4,
        OP_SCAN_DN = 3'd5
    } bitop_e;

    function automatic logic op_is_scan(input logic [2:0] code);
        return (code == OP_SCAN_UP) || (code == OP_SCAN_DN);
    endfunction

endpackage

// File: rtl/bitop_modify.sv
// Selects one bit of the operand, reports whether it was zero, and writes
// back the operand with that bit kept, cleared, set or inverted.
// Assumes BITNUM_W >= clog2(DATA_W). In narrow mode only the low NARROW_W
// bits can be addressed, so upper bits always pass through unchanged.
module bitop_modify #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int BITNUM_W = 8
) (
    input  logic [DATA_W-1:0]   operand,
    input  logic [BITNUM_W-1:0] bitnum,
    input  logic                wide,
    input  logic [2:0]          op,
    output logic [DATA_W-1:0]   result,
    output logic                was_zero
);
    import bitop_pkg::*;

    localparam int POS_W  = $clog2(DATA_W);
    localparam int NPOS_W = $clog2(NARROW_W);

    logic [POS_W-1:0]  pos;
    logic [DATA_W-1:0] sel_mask;

    // Reduce the bit number modulo the active width.
    always_comb begin
        if (wide) pos = bitnum[POS_W-1:0];
        else      pos = POS_W'(bitnum[NPOS_W-1:0]);
        sel_mask = DATA_W'(1) << pos;
    end

    // Sample the old bit and apply the requested write.
    always_comb begin
        was_zero = ((operand & sel_mask) == '0);
        case (op)
            OP_CLEAR:  result = operand & ~sel_mask;
            OP_SET:    result = operand | sel_mask;
            OP_INVERT: result = operand ^ sel_mask;
            default:   result = operand;
        endcase
    end

endmodule

// File: rtl/bitop_scan.sv
// Priority search for the first set bit of the operand, restricted to the
// low HALF_W bits when wide is 0. REVERSE picks the search direction:
// 0 finds the lowest set bit, 1 the highest. The index is 0 when nothing
// is found.
module bitop_scan #(
    parameter int DATA_W  = 32,
    parameter int HALF_W  = 16,
    parameter bit REVERSE = 1'b0
) (
    input  logic                      operand_wide,
    input  logic [DATA_W-1:0]         operand,
    output logic [$clog2(DATA_W)-1:0] index,
    output logic                      found
);
    localparam int POS_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] view;

    // Clip the operand to the active scan width.
    always_comb view = operand_wide ? operand : (operand & HALF_MASK);

    generate
        if (REVERSE) begin : g_high_first
            // Ascending sweep: the last hit is the highest set bit.
            always_comb begin
                index = '0;
                for (int i = 0; i < DATA_W; i++)
                    if (view[i]) index = POS_W'(i);
            end
        end else begin : g_low_first
            // Descending sweep: the last hit is the lowest set bit.
            always_comb begin
                index = '0;
                for (int i = DATA_W - 1; i >= 0; i--)
                    if (view[i]) index = POS_W'(i);
            end
        end
    endgenerate

    // Any set bit in the view means the search succeeded.
    always_comb found = |view;

endmodule

// File: rtl/bitop_unit.sv
// Top of the bit test/modify/scan unit. It combines the bit modifier and the
// two scan directions and registers one result per accepted request.
// Assumes one request per cycle. Results hold between requests, and only
// the valid strobe falls when the unit is idle.
module bitop_unit #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int HALF_W   = 16,
    parameter int BITNUM_W = 8,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_op,
    input  logic                in_wide,
    input  logic [DATA_W-1:0]   in_operand,
    input  logic [BITNUM_W-1:0] in_bitnum,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_result,
    output logic                out_zero,
    output logic [POS_W-1:0]    out_index,
    output logic                out_empty
);
    import bitop_pkg::*;

    logic [DATA_W-1:0] mod_result;
    logic              mod_zero;
    logic [POS_W-1:0]  up_index, dn_index;
    logic              up_found, dn_found;

    logic [DATA_W-1:0] nxt_result;
    logic              nxt_zero, nxt_empty;
    logic [POS_W-1:0]  nxt_index;

    bitop_modify #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .BITNUM_W(BITNUM_W)
    ) u_modify (
        .operand (in_operand),
        .bitnum  (in_bitnum),
        .wide    (in_wide),
        .op      (in_op),
        .result  (mod_result),
        .was_zero(mod_zero)
    );

    bitop_scan #(
        .DATA_W(DATA_W), .HALF_W(HALF_W), .REVERSE(1'b0)
    ) u_scan_up (
        .operand_wide(in_wide),
        .operand     (in_operand),
        .index       (up_index),
        .found       (up_found)
    );

    bitop_scan #(
        .DATA_W(DATA_W), .HALF_W(HALF_W), .REVERSE(1'b1)
    ) u_scan_dn (
        .operand_wide(in_wide),
        .operand     (in_operand),
        .index       (dn_index),
        .found       (dn_found)
    );

    // Select the outcome that belongs to the requested operation.
    always_comb begin
        nxt_result = mod_result;
        nxt_zero   = mod_zero;
        nxt_index  = '0;
        nxt_empty  = 1'b0;
        if (in_op == OP_SCAN_UP) begin
            nxt_result = in_operand;
            nxt_index  = up_found ? up_index : '0;
            nxt_empty  = ~up_found;
            nxt_zero   = ~up_found;
        end else if (in_op == OP_SCAN_DN) begin
            nxt_result = in_operand;
            nxt_index  = dn_found ? dn_index : '0;
            nxt_empty  = ~dn_found;
            nxt_zero   = ~dn_found;
        end
    end

    // Register the strobe every cycle and the payload only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zero   <= 1'b0;
            out_index  <= '0;
            out_empty  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_result;
                out_zero   <= nxt_zero;
                out_index  <= nxt_index;
                out_empty  <= nxt_empty;
            end
        end
    end

endmodule

// File: rtl/bitop_unit_chk.sv
// Temporal checks on the ports of bitop_unit, attached through bind.
// Assumes the opcode codes defined in bitop_pkg.
module bitop_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int BITNUM_W = 8,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          in_op,
    input logic                in_wide,
    input logic [DATA_W-1:0]   in_operand,
    input logic [BITNUM_W-1:0] in_bitnum,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_result,
    input logic                out_zero,
    input logic [POS_W-1:0]    out_index,
    input logic                out_empty
);
    import bitop_pkg::*;

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_zero)
                       && $stable(out_index) && $stable(out_empty)));

    p_test_keeps_operand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_TEST) |=> (out_result == $past(in_operand)));

    p_narrow_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_is_scan(in_op) && !in_wide)
        |=> (out_result[DATA_W-1:NARROW_W] == $past(in_operand[DATA_W-1:NARROW_W])));

    p_empty_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_empty) |-> (out_index == '0 && out_zero));

    p_scan_nonzero_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_scan(in_op) && in_wide && in_operand != '0)
        |=> (!out_empty && !out_zero));

    p_bitop_no_scan_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_is_scan(in_op)) |=> (!out_empty && out_index == '0));

    p_single_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_INVERT)
        |=> ($countones(out_result ^ $past(in_operand)) == 1));

endmodule

bind bitop_unit bitop_unit_chk #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .BITNUM_W(BITNUM_W)
) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic [31:0] in_operand = '0;
    logic [7:0]  in_bitnum = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_zero;
    logic [4:0]  out_index;
    logic        out_empty;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit armed = 1'b0;

    // Expected state of the outputs, maintained behaviourally.
    logic        e_valid = 1'b0;
    logic [31:0] e_result = '0;
    logic        e_zero = 1'b0;
    int          e_index = 0;
    logic        e_empty = 1'b0;
    string       e_tag = "R8";

    always #10 clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_operand(in_operand), .in_bitnum(in_bitnum),
        .out_valid(out_valid), .out_result(out_result), .out_zero(out_zero),
        .out_index(out_index), .out_empty(out_empty)
    );

    // Reference: compute the expected outcome of one request.
    task automatic model(input int op, input bit wide, input logic [31:0] opd, input int bn);
        int width;
        int pos;
        int hit;
        width = wide ? 32 : 16;
        if (op == 4 || op == 5) begin
            hit = -1;
            if (op == 4) begin
                for (int i = 0; i < width; i++) if (hit < 0 && opd[i]) hit = i;
            end else begin
                for (int i = width - 1; i >= 0; i--) if (hit < 0 && opd[i]) hit = i;
            end
            e_result = opd;
            e_empty  = (hit < 0);
            e_zero   = (hit < 0);
            e_index  = (hit < 0) ? 0 : hit;
            e_tag    = (hit < 0) ? "R6" : ((op == 4) ? "R4" : "R5");
        end else begin
            pos = wide ? (bn % 32) : (bn % 8);
            e_zero   = (opd[pos] == 1'b0);
            e_result = opd;
            if (op == 1) e_result[pos] = 1'b0;
            if (op == 2) e_result[pos] = 1'b1;
            if (op == 3) e_result[pos] = ~opd[pos];
            e_index = 0;
            e_empty = 1'b0;
            if (op == 0)      e_tag = "R1";
            else if (op >= 6) e_tag = "R9";
            else              e_tag = wide ? "R2" : "R3";
        end
    endtask

    // Advance the reference at each edge from the inputs it saw.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 1'b0; e_result = '0; e_zero = 1'b0; e_index = 0; e_empty = 1'b0;
            e_tag = "R8";
            armed = 1'b1;
        end else begin
            e_valid = in_valid;
            if (in_valid) model(in_op, in_wide, in_operand, in_bitnum);
            else e_tag = "R7";
        end
    end

    // Compare every output against the reference away from the edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (out_valid !== e_valid || out_result !== e_result || out_zero !== e_zero
                || out_index !== 5'(e_index) || out_empty !== e_empty) begin
                failures++;
                $display("FAIL %s: actual v=%b res=%h z=%b idx=%0d emp=%b expected v=%b res=%h z=%b idx=%0d emp=%b",
                         e_tag, out_valid, out_result, out_zero, out_index, out_empty,
                         e_valid, e_result, e_zero, e_index, e_empty);
            end
        end
    end

    task automatic send(input int op, input bit wide, input logic [31:0] opd, input int bn);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op); in_wide = wide; in_operand = opd; in_bitnum = 8'(bn);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_operand = $urandom;
            in_op = 3'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 test and R9 reserved codes
        send(0, 1, 32'h0000_0010, 4);
        send(0, 1, 32'h0000_0010, 5);
        send(6, 1, 32'hFFFF_FFFF, 31);
        send(7, 0, 32'h0000_0000, 200);
        // R2 wide modify, bit numbers wrapping past 31
        send(1, 1, 32'hFFFF_FFFF, 31);
        send(2, 1, 32'h0000_0000, 32);
        send(3, 1, 32'h8000_0001, 63);
        send(3, 1, 32'h8000_0001, 255);
        // R3 narrow modify, modulo 8 and upper bits kept
        send(1, 0, 32'hFFFF_FFFF, 15);
        send(2, 0, 32'hABCD_EF00, 8);
        send(3, 0, 32'h1234_5680, 7);
        idle(3);   // R7 hold
        // R4 / R5 / R6 scans with edge patterns
        send(4, 1, 32'h8000_0000, 0);
        send(5, 1, 32'h8000_0000, 0);
        send(4, 0, 32'hFFFF_0000, 0);
        send(5, 0, 32'hFFFF_0000, 0);
        send(5, 0, 32'h0001_8000, 0);
        send(4, 0, 32'h0003_0001, 0);
        send(4, 1, 32'h0000_0000, 0);
        send(5, 1, 32'hFFFF_FFFF, 0);
        send(4, 1, 32'hFFFF_FFFF, 0);
        idle(2);
        // Mixed random traffic with shaped operands and gaps
        for (int n = 0; n < 600; n++) begin
            logic [31:0] v;
            v = $urandom;
            case ($urandom % 4)
                0: v = 32'h1 << ($urandom % 32);
                1: v = v & 32'hFFFF_0000;
                2: v = v & 32'h0000_FFFF;
                default: ;
            endcase
            if ($urandom % 5 == 0) idle(1 + $urandom % 3);
            send($urandom % 8, $urandom % 2, v, $urandom % 256);
        end
        idle(2);
        // R8 reset in mid-stream
        send(2, 1, 32'h0, 3);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule